// File: doc/BRIEF.md
# Break-Protected Status Flag Bank

This block holds a bank of status flags for a peripheral. Each flag is set by a hardware event and cleared by software in two steps, done in order. First, software reads the status register while the flag is set, which arms the clear. Then software accesses a second register, which completes it. Bus decoding lives outside the block, so every access reaches it only as a per-flag strobe.

A debug halt ("break") must not destroy status information while a debugger reads and writes registers freely. To allow this, the bank has a shared clear-enable bit that software can write. While break is active and the bit is 0, every clearing path is gated off. The armed state and the flags keep their values. When break ends, a clear that was armed before break completes as normal on the next second step. When the bit is 1, clearing works inside break as it does outside it, and a flag cleared there stays cleared after break ends.

Top module: `brk_flag_bank`

## Requirements
- R1: A pulse on `set_i[i]` makes `flag_o[i]` 1 at the next clock edge.
- R2: Outside break, a `step1_i[i]` pulse while `flag_o[i]` is 1 arms the clear, and a later `step2_i[i]` pulse clears `flag_o[i]` at its edge. A `step2_i[i]` pulse that has no armed clear behind it leaves the flag set.
- R3: While `brk_i` is 1 and `clr_en_o` is 0, neither strobe changes the flag or the armed state. A `step1_i` given during that time therefore does not let a later `step2_i` clear the flag.
- R4: While `brk_i` is 1 and `clr_en_o` is 1, the two-step sequence clears the flag exactly as it does outside break.
- R5: A flag cleared during break stays 0 after `brk_i` returns to 0.
- R6: A clear armed before break survives a protected break. A `step2_i` inside that break leaves the flag set, and a `step2_i` after break ends clears it.
- R7: A `set_i` in the same cycle as a `step2_i` leaves the flag set and drops the armed state, so a further `step2_i` does not clear it.
- R8: A `set_i` between `step1_i` and `step2_i` drops the armed state, so the following `step2_i` does not clear the flag.
- R9: Reset (`rst_ni` low) clears all flags, all armed states and the clear-enable bit.
- R10: When `clr_en_we_i` is 1, the value on `clr_en_d_i` appears on `clr_en_o` after the next clock edge. Otherwise `clr_en_o` holds its value.
- R11: The strobes for flag i do not affect any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | Break mode active |
| clr_en_we_i | input | 1 | Write strobe for the clear-enable bit |
| clr_en_d_i | input | 1 | Value to write into the clear-enable bit |
| clr_en_o | output | 1 | Current clear-enable bit |
| set_i | input | N_FLAGS | Per-flag hardware set event |
| step1_i | input | N_FLAGS | Per-flag status-read strobe (first clearing step) |
| step2_i | input | N_FLAGS | Per-flag second-register access strobe (second clearing step) |
| flag_o | output | N_FLAGS | Flag values |

## Verification
The armed state has no output of its own. A wrong value shows only when a later `step2_i` clears a flag that should stay set, or fails to clear one that should go to 0. The bench therefore follows every arming, protection or disarming scenario with a second step and samples `flag_o` one edge after that step. A wrong gate decision during break can stay hidden until break ends. For that reason the protected-break tests check the flag both inside break and again after the first second step that follows the exit.

// File: rtl/brk_flag_pkg.sv
package brk_flag_pkg;
  // Per-flag software/hardware strobes
  typedef struct packed {
    logic set;
    logic step1;
    logic step2;
  } flag_strobe_t;
endpackage

// File: rtl/brk_clr_ctrl.sv
module brk_clr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic we_i,
  input  logic d_i,
  output logic en_o,
  output logic clr_ok_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= d_i;
  end

  assign en_o     = en_q;
  // Clearing paths are open outside break, or inside break when enabled
  assign clr_ok_o = !brk_i || en_q;
endmodule

// File: rtl/brk_flag_cell.sv
module brk_flag_cell
  import brk_flag_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ok_i,
  input  flag_strobe_t stb_i,
  output logic         flag_o
);
  logic flag_q, arm_q;

  // Priority: set > completed clear > arming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (stb_i.set) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (clr_ok_i && arm_q && stb_i.step2) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (clr_ok_i && stb_i.step1 && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/brk_flag_bank.sv
module brk_flag_bank
  import brk_flag_pkg::*;
#(
  parameter int N_FLAGS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               brk_i,
  input  logic               clr_en_we_i,
  input  logic               clr_en_d_i,
  output logic               clr_en_o,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] step1_i,
  input  logic [N_FLAGS-1:0] step2_i,
  output logic [N_FLAGS-1:0] flag_o
);
  logic clr_ok;

  brk_clr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .brk_i    (brk_i),
    .we_i     (clr_en_we_i),
    .d_i      (clr_en_d_i),
    .en_o     (clr_en_o),
    .clr_ok_o (clr_ok)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_cell
    flag_strobe_t stb;
    assign stb = '{set: set_i[g], step1: step1_i[g], step2: step2_i[g]};

    brk_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_ok_i (clr_ok),
      .stb_i    (stb),
      .flag_o   (flag_o[g])
    );
  end
endmodule

// File: rtl/brk_flag_bank_chk.sv
module brk_flag_bank_chk #(
  parameter int N_FLAGS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               brk_i,
  input logic               clr_en_we_i,
  input logic               clr_en_d_i,
  input logic               clr_en_o,
  input logic [N_FLAGS-1:0] set_i,
  input logic [N_FLAGS-1:0] step2_i,
  input logic [N_FLAGS-1:0] flag_o
);
  p_en_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_we_i |=> clr_en_o == $past(clr_en_d_i));

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_we_i |=> $stable(clr_en_o));

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_chk
    p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);

    p_protect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_i && !clr_en_o && flag_o[g]) |=> flag_o[g]);

    p_clear_needs_step2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !step2_i[g]) |=> flag_o[g]);

    p_rise_needs_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

bind brk_flag_bank brk_flag_bank_chk #(.N_FLAGS(N_FLAGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .brk_i       (brk_i),
  .clr_en_we_i (clr_en_we_i),
  .clr_en_d_i  (clr_en_d_i),
  .clr_en_o    (clr_en_o),
  .set_i       (set_i),
  .step2_i     (step2_i),
  .flag_o      (flag_o)
);

// File: tb/sim_brk_flag_bank.sv
`timescale 1ns/1ps
module sim_brk_flag_bank;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          brk = 1'b0;
  logic          en_we = 1'b0;
  logic          en_d = 1'b0;
  logic          en_o;
  logic [NF-1:0] set = '0, s1 = '0, s2 = '0;
  logic [NF-1:0] flag;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  brk_flag_bank #(.N_FLAGS(NF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk),
    .clr_en_we_i(en_we), .clr_en_d_i(en_d), .clr_en_o(en_o),
    .set_i(set), .step1_i(s1), .step2_i(s2), .flag_o(flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply strobes for one cycle at a negedge; outputs are valid at the next negedge
  task automatic pulse(input logic [NF-1:0] st, input logic [NF-1:0] a, input logic [NF-1:0] b);
    set = st; s1 = a; s2 = b;
    @(negedge clk);
    set = '0; s1 = '0; s2 = '0;
  endtask

  task automatic write_en(input logic v);
    en_we = 1'b1; en_d = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 flags after reset", flag, 0);
    chk("R9 enable after reset", en_o, 0);
  endtask

  task automatic t_set;
    pulse(4'b0001, 0, 0);
    chk("R1 set flag0", flag, 4'b0001);
  endtask

  task automatic t_clear;
    pulse(0, 0, 4'b0001);
    chk("R2 step2 without arm", flag, 4'b0001);
    pulse(0, 4'b0001, 0);
    chk("R2 step1 keeps flag", flag, 4'b0001);
    pulse(0, 0, 4'b0001);
    chk("R2 step2 clears", flag, 4'b0000);
  endtask

  task automatic t_indep;
    pulse(4'b0011, 0, 0);
    pulse(0, 4'b0010, 0);
    pulse(0, 0, 4'b0010);
    chk("R11 only flag1 cleared", flag, 4'b0001);
    pulse(0, 4'b0001, 0);
    pulse(0, 0, 4'b0001);
    chk("R11 flag0 cleared", flag, 4'b0000);
  endtask

  task automatic t_en;
    write_en(1'b1);
    chk("R10 enable write 1", en_o, 1);
    @(negedge clk);
    chk("R10 enable holds", en_o, 1);
    write_en(1'b0);
    chk("R10 enable write 0", en_o, 0);
  endtask

  task automatic t_protect;
    pulse(4'b0100, 0, 0);
    brk = 1'b1;
    pulse(0, 4'b0100, 0);
    pulse(0, 0, 4'b0100);
    chk("R3 protected break keeps flag", flag, 4'b0100);
    brk = 1'b0;
    @(negedge clk);
    pulse(0, 0, 4'b0100);
    chk("R3 step1 in protected break did not arm", flag, 4'b0100);
    pulse(0, 4'b0100, 0);
    pulse(0, 0, 4'b0100);
    chk("R2 normal clear after break", flag, 4'b0000);
  endtask

  task automatic t_brk_en;
    write_en(1'b1);
    pulse(4'b1000, 0, 0);
    brk = 1'b1;
    pulse(0, 4'b1000, 0);
    pulse(0, 0, 4'b1000);
    chk("R4 clear in enabled break", flag, 4'b0000);
    brk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 stays cleared after break", flag, 4'b0000);
    write_en(1'b0);
  endtask

  task automatic t_pre_arm;
    pulse(4'b0001, 0, 0);
    pulse(0, 4'b0001, 0);
    brk = 1'b1;
    pulse(0, 0, 4'b0001);
    chk("R6 step2 in protected break", flag, 4'b0001);
    @(negedge clk);
    brk = 1'b0;
    @(negedge clk);
    chk("R6 flag kept at exit", flag, 4'b0001);
    pulse(0, 0, 4'b0001);
    chk("R6 step2 after exit clears", flag, 4'b0000);
  endtask

  task automatic t_set_vs_clear;
    pulse(4'b0010, 0, 0);
    pulse(0, 4'b0010, 0);
    pulse(4'b0010, 0, 4'b0010);
    chk("R7 set wins over step2", flag, 4'b0010);
    pulse(0, 0, 4'b0010);
    chk("R7 arm dropped by set", flag, 4'b0010);
    pulse(0, 4'b0010, 0);
    pulse(0, 0, 4'b0010);
    chk("R7 cleanup clear", flag, 4'b0000);
  endtask

  task automatic t_set_drops;
    pulse(4'b0100, 0, 0);
    pulse(0, 4'b0100, 0);
    pulse(4'b0100, 0, 0);
    pulse(0, 0, 4'b0100);
    chk("R8 set between steps disarms", flag, 4'b0100);
  endtask

  task automatic t_reset_mid;
    write_en(1'b1);
    pulse(0, 4'b0100, 0);  // arm flag2
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 flags after second reset", flag, 0);
    chk("R9 enable after second reset", en_o, 0);
    pulse(4'b0100, 0, 0);
    pulse(0, 0, 4'b0100);
    chk("R9 arm cleared by reset", flag, 4'b0100);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_indep();
    t_en();
    t_protect();
    t_brk_en();
    t_pre_arm();
    t_set_vs_clear();
    t_set_drops();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule